// File: doc/BRIEF.md
# Transmit Descriptor Fetch Engine

This block is the transmit half of a bus-mastering network controller. It rests in a suspended state until software writes the poll-demand register while transmission is enabled. It then walks a ring of four-word descriptors held in memory. For each descriptor that hardware owns, it reads the buffer a word at a time and presents the bytes on a byte stream. It then writes a completion status back over the descriptor's status word and moves on to the next descriptor. The walk ends when it meets a descriptor that software still owns.

A descriptor flagged as a setup frame carries an address-filter table and not a packet. Its bytes leave on a separate filter port, and the transmit stream stays silent for them. Descriptors with an illegal length are completed at once with the error summary bit set, and no bytes are moved for them. A flag in the control word closes the ring, and the engine then returns to the ring base register.

Memory is modelled as a simple word-addressed port. Read data appears on `mem_rdata` in the cycle after `mem_rd` is asserted. A write takes effect at the clock edge on which `mem_we` is high.

Top module: `tx_desc_fetch`

## Requirements
- R1: After reset the engine is suspended: `tx_valid`, `flt_valid`, `mem_rd` and `mem_we` all stay low until software starts it.
- R2: The register port decodes `reg_sel`: 0 is the ring base, 1 is poll demand and 2 is the mode register. A write of any value to poll demand starts a descriptor fetch only when mode bit 13 (transmit enable) is set. A poll-demand write while that bit is clear causes no memory access and no output.
- R3: If the fetched status word has bit 31 (ownership) clear, the engine returns to the suspended state without writing back and without moving its ring pointer. A later poll therefore fetches the same descriptor.
- R4: Descriptor word 0 is status, word 1 is control and word 2 is the buffer word address. Control bits [10:0] give the byte count. Bytes leave one per `tx_valid` cycle, taken from consecutive buffer words, least significant byte first.
- R5: `tx_first` marks the first byte of a buffer whose control bit 29 (first segment) is set. `tx_last` marks the final byte of a buffer whose control bit 30 (last segment) is set. Neither flag appears on any other byte.
- R6: When control bit 27 (setup frame) is set, the buffer bytes appear on `flt_valid`/`flt_data` in the same order, and `tx_valid` stays low.
- R7: On completion the engine writes the status word with bit 31 cleared. Bit 15 (error summary) is set, and no byte is moved, when the byte count is zero or a setup frame's count differs from 192. Otherwise the written word is zero.
- R8: After a completion the engine advances by four words and fetches the next descriptor without a new poll. It keeps doing so until it finds a descriptor owned by software.
- R9: After a descriptor with control bit 25 (end of ring) set, the next fetch is from the ring base address.
- R10: Writing the ring base register while the engine is suspended also sets the current descriptor pointer to that address.
- R11: Clearing mode bit 13 lets the descriptor in progress complete. The engine then suspends instead of fetching the next descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 base, 1 poll, 2 mode) |
| reg_wdata | input | 32 | Register write data |
| mem_rd | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after `mem_rd` |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_first | output | 1 | First byte of a first segment |
| tx_last | output | 1 | Final byte of a last segment |
| flt_valid | output | 1 | Filter-table byte valid |
| flt_data | output | 8 | Filter-table byte |

## Verification
From the ports it is hard to tell an end-of-ring wrap apart from a plain four-word step, because both end with the engine suspended. The bench separates the two by placing a software-owned descriptor right after the wrapping one. It then hands the wrapping descriptor back to hardware with a new buffer, so only a fetch from the base can produce the new byte. The same re-arming trick shows that a software-owned descriptor leaves the pointer in place. Stopping mid-chain is reached by clearing transmit enable one cycle after the poll, while the first descriptor is still being fetched.

// File: rtl/tdfe_pkg.sv
package tdfe_pkg;
  localparam int OWN_B   = 31;
  localparam int LS_B    = 30;
  localparam int FS_B    = 29;
  localparam int SETUP_B = 27;
  localparam int EOR_B   = 25;
  localparam int ES_B    = 15;
  localparam int TXEN_B  = 13;

  localparam logic [1:0] SEL_BASE = 2'd0;
  localparam logic [1:0] SEL_POLL = 2'd1;
  localparam logic [1:0] SEL_MODE = 2'd2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_STS, ST_CTL, ST_BUF, ST_RDW, ST_CAP, ST_EMIT, ST_WB
  } tx_state_e;

  // pick byte lane of a little-endian word
  function automatic logic [7:0] lane_byte(input logic [31:0] w, input logic [1:0] lane);
    return w[{lane, 3'b000} +: 8];
  endfunction

  // status word written back on completion
  function automatic logic [31:0] completion_word(input logic err);
    logic [31:0] r;
    r = '0;
    r[ES_B] = err;
    return r;
  endfunction
endpackage

// File: rtl/tdfe_regs.sv
module tdfe_regs #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [AW-1:0] ring_base,
  output logic          tx_en,
  output logic          poll_req,
  output logic          base_wr
);
  import tdfe_pkg::*;

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  always_comb begin
    poll_req = reg_wr && (reg_sel == SEL_POLL);
    base_wr  = reg_wr && (reg_sel == SEL_BASE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_base <= '0;
      tx_en     <= 1'b0;
    end else begin
      if (base_wr) ring_base <= reg_wdata[AW-1:0];
      if (reg_wr && reg_sel == SEL_MODE) tx_en <= reg_wdata[TXEN_B];
    end
  end
endmodule

// File: rtl/tdfe_ring_ptr.sv
module tdfe_ring_ptr #(
  parameter int AW         = 10,
  parameter int DESC_WORDS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic [AW-1:0] base,
  input  logic          adv,
  input  logic          eor,
  output logic [AW-1:0] cur
);
  localparam logic [AW-1:0] STEP = AW'(DESC_WORDS);

  always_ff @(posedge clk) begin
    if (!rst_n)        cur <= '0;
    else if (load)     cur <= load_val;
    else if (adv)      cur <= eor ? base : cur + STEP;
  end

  // R8: plain advance moves by one descriptor
  p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !eor && !load) |=> cur == $past(cur) + STEP);

  // R9: end-of-ring returns to the ring base
  p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && eor && !load) |=> cur == $past(base));

  // R10: base load sets the pointer
  p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cur == $past(load_val));
endmodule

// File: rtl/tdfe_byte_emit.sv
module tdfe_byte_emit (
  input  logic        emit,
  input  logic        setup,
  input  logic [31:0] word,
  input  logic [1:0]  lane,
  input  logic        first_b,
  input  logic        last_b,
  input  logic        fs,
  input  logic        ls,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_first,
  output logic        tx_last,
  output logic        flt_valid,
  output logic [7:0]  flt_data
);
  import tdfe_pkg::*;

  logic [7:0] cur_byte;

  always_comb begin
    cur_byte  = lane_byte(word, lane);
    tx_valid  = emit && !setup;
    flt_valid = emit && setup;
    tx_data   = tx_valid ? cur_byte : 8'h00;
    flt_data  = flt_valid ? cur_byte : 8'h00;
    tx_first  = tx_valid && fs && first_b;
    tx_last   = tx_valid && ls && last_b;
  end
endmodule

// File: rtl/tx_desc_fetch.sv
module tx_desc_fetch #(
  parameter int AW         = 10,
  parameter int COUNT_W    = 11,
  parameter int DESC_WORDS = 4,
  parameter int SETUP_LEN  = 192
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic          mem_rd,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_first,
  output logic          tx_last,
  output logic          flt_valid,
  output logic [7:0]    flt_data
);
  import tdfe_pkg::*;

  localparam logic [COUNT_W-1:0] SETUP_CNT = COUNT_W'(SETUP_LEN);
  localparam logic [COUNT_W-1:0] ONE_CNT   = COUNT_W'(1);

  tx_state_e            state;
  logic [AW-1:0]        cur, ring_base;
  logic                 tx_en, poll_req, base_wr;
  logic                 fs_q, ls_q, setup_q, eor_q, err_q, first_q;
  logic [COUNT_W-1:0]   cnt_q, remain_q;
  logic [AW-1:0]        wptr;
  logic [31:0]          word_q;
  logic [1:0]           lane_q;

  // named internal events
  logic ev_start, ev_sw_owned, ev_done, ptr_load, desc_bad, emit;

  function automatic logic bad_length(input logic [COUNT_W-1:0] n, input logic is_setup);
    return (n == '0) || (is_setup && n != SETUP_CNT);
  endfunction

  assign ev_start    = (state == ST_IDLE) && poll_req && tx_en;
  assign ev_sw_owned = (state == ST_STS) && !mem_rdata[OWN_B];
  assign ev_done     = (state == ST_WB);
  assign ptr_load    = base_wr && (state == ST_IDLE);
  assign desc_bad    = bad_length(cnt_q, setup_q);
  assign emit        = (state == ST_EMIT);

  tdfe_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ring_base(ring_base), .tx_en(tx_en),
    .poll_req(poll_req), .base_wr(base_wr)
  );

  tdfe_ring_ptr #(.AW(AW), .DESC_WORDS(DESC_WORDS)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(reg_wdata[AW-1:0]),
    .base(ring_base), .adv(ev_done), .eor(eor_q), .cur(cur)
  );

  tdfe_byte_emit u_emit (
    .emit(emit), .setup(setup_q), .word(word_q), .lane(lane_q),
    .first_b(first_q), .last_b(remain_q == ONE_CNT), .fs(fs_q), .ls(ls_q),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_first(tx_first),
    .tx_last(tx_last), .flt_valid(flt_valid), .flt_data(flt_data)
  );

  // memory request decode
  always_comb begin
    mem_rd    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur;
    mem_wdata = '0;
    case (state)
      ST_FETCH: mem_rd = 1'b1;
      ST_STS: if (mem_rdata[OWN_B]) begin
        mem_rd   = 1'b1;
        mem_addr = cur + AW'(1);
      end
      ST_CTL: begin
        mem_rd   = 1'b1;
        mem_addr = cur + AW'(2);
      end
      ST_RDW: begin
        mem_rd   = 1'b1;
        mem_addr = wptr;
      end
      ST_WB: begin
        mem_we    = 1'b1;
        mem_wdata = completion_word(err_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      fs_q     <= 1'b0;
      ls_q     <= 1'b0;
      setup_q  <= 1'b0;
      eor_q    <= 1'b0;
      err_q    <= 1'b0;
      first_q  <= 1'b0;
      cnt_q    <= '0;
      remain_q <= '0;
      wptr     <= '0;
      word_q   <= '0;
      lane_q   <= '0;
    end else begin
      case (state)
        ST_IDLE:  if (ev_start) state <= ST_FETCH;
        ST_FETCH: state <= ST_STS;
        ST_STS:   state <= ev_sw_owned ? ST_IDLE : ST_CTL;
        ST_CTL: begin
          fs_q    <= mem_rdata[FS_B];
          ls_q    <= mem_rdata[LS_B];
          setup_q <= mem_rdata[SETUP_B];
          eor_q   <= mem_rdata[EOR_B];
          cnt_q   <= mem_rdata[COUNT_W-1:0];
          state   <= ST_BUF;
        end
        ST_BUF: begin
          wptr     <= mem_rdata[AW-1:0];
          remain_q <= cnt_q;
          lane_q   <= '0;
          first_q  <= 1'b1;
          err_q    <= desc_bad;
          state    <= desc_bad ? ST_WB : ST_RDW;
        end
        ST_RDW: state <= ST_CAP;
        ST_CAP: begin
          word_q <= mem_rdata;
          state  <= ST_EMIT;
        end
        ST_EMIT: begin
          first_q  <= 1'b0;
          remain_q <= remain_q - ONE_CNT;
          if (remain_q == ONE_CNT) begin
            state <= ST_WB;
          end else if (lane_q == 2'd3) begin
            lane_q <= '0;
            wptr   <= wptr + AW'(1);
            state  <= ST_RDW;
          end else begin
            lane_q <= lane_q + 2'd1;
          end
        end
        ST_WB:   state <= tx_en ? ST_FETCH : ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: poll while disabled leaves the engine suspended
  p_poll_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && poll_req && !tx_en) |=> (state == ST_IDLE && !mem_rd));

  // R3: software-owned descriptor suspends with the pointer unchanged
  p_own_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sw_owned |=> (state == ST_IDLE && $stable(cur)));

  // R5: segment flags only on valid transmit bytes
  p_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_first || tx_last) |-> tx_valid);

  // R6: filter and transmit streams never overlap
  p_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_valid, flt_valid}));

  // R7: an erroneous descriptor goes straight to write-back
  p_err_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && err_q) |-> $past(state) == ST_BUF);

  // R7: write-back always releases ownership
  p_wb_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !mem_wdata[OWN_B]);

  // R11: disabled engine suspends after the current completion
  p_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && !tx_en) |=> state == ST_IDLE);
endmodule

// File: tb/tb_tx_desc_fetch.sv
module tb_tx_desc_fetch;
  localparam int AW = 10;
  localparam logic [31:0] OWN   = 32'h8000_0000;
  localparam logic [31:0] LSEG  = 32'h4000_0000;
  localparam logic [31:0] FSEG  = 32'h2000_0000;
  localparam logic [31:0] SETF  = 32'h0800_0000;
  localparam logic [31:0] EORF  = 32'h0200_0000;
  localparam logic [31:0] ESF   = 32'h0000_8000;
  localparam logic [31:0] TXEN  = 32'h0000_2000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, reg_wr;
  logic [1:0]    reg_sel;
  logic [31:0]   reg_wdata;
  logic          mem_rd, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic          tx_valid, tx_first, tx_last, flt_valid;
  logic [7:0]    tx_data, flt_data;

  tx_desc_fetch #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .mem_rd(mem_rd), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_first(tx_first),
    .tx_last(tx_last), .flt_valid(flt_valid), .flt_data(flt_data)
  );

  logic [31:0] mem [0:(1<<AW)-1];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  int checks = 0, errors = 0;
  int tx_n, flt_n, rd_n, we_n, first_cnt, last_cnt, first_at, last_at;
  logic [7:0] txb [0:511];
  logic [7:0] fltb [0:511];

  always @(negedge clk) if (rst_n) begin
    if (tx_valid) begin
      txb[tx_n % 512] = tx_data;
      if (tx_first) begin first_cnt++; first_at = tx_n; end
      if (tx_last)  begin last_cnt++;  last_at  = tx_n; end
      tx_n++;
    end
    if (flt_valid) begin fltb[flt_n % 512] = flt_data; flt_n++; end
    if (mem_rd) rd_n++;
    if (mem_we) we_n++;
  end

  task automatic clear_mon();
    tx_n = 0; flt_n = 0; rd_n = 0; we_n = 0;
    first_cnt = 0; last_cnt = 0; first_at = -1; last_at = -1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic put_desc(input int a, input logic [31:0] st, input logic [31:0] ctl, input logic [31:0] bufa);
    mem[a] = st; mem[a+1] = ctl; mem[a+2] = bufa; mem[a+3] = 32'h0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] setup_byte(input int k);
    return 8'(k) ^ 8'h5A;
  endfunction

  task automatic t_reset();
    clear_mon();
    settle(5);
    chk("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
    chk("R1 flt_valid", {31'b0, flt_valid}, 32'h0);
    chk("R1 mem accesses", rd_n + we_n, 32'h0);
  endtask

  task automatic t_disabled();
    reg_write(2'd0, 32'd16);
    put_desc(16, OWN, FSEG | LSEG | 32'd4, 32'd100);
    clear_mon();
    reg_write(2'd1, 32'h0);
    settle(50);
    chk("R2 no read while disabled", rd_n, 32'h0);
    chk("R2 no bytes while disabled", tx_n, 32'h0);
    chk("R2 status untouched", mem[16], OWN);
  endtask

  task automatic t_frame();
    reg_write(2'd2, TXEN);
    put_desc(16, OWN, FSEG | LSEG | 32'd5, 32'd100);
    mem[20] = 32'h0;
    mem[100] = 32'h4433_2211; mem[101] = 32'h0000_0055;
    clear_mon();
    reg_write(2'd1, 32'hDEAD_BEEF);
    settle(100);
    chk("R4 byte count", tx_n, 32'd5);
    for (int i = 0; i < 5; i++) chk("R4 byte order", {24'b0, txb[i]}, 32'h11 * (i + 1));
    chk("R5 first count", first_cnt, 32'd1);
    chk("R5 first position", first_at, 32'd0);
    chk("R5 last count", last_cnt, 32'd1);
    chk("R5 last position", last_at, 32'd4);
    chk("R7 clean completion", mem[16], 32'h0);
  endtask

  task automatic t_sw_owned();
    reg_write(2'd0, 32'd30);
    put_desc(30, 32'h0000_1234, FSEG | LSEG | 32'd1, 32'd130);
    mem[130] = 32'h0000_00A5;
    clear_mon();
    reg_write(2'd1, 32'h0);
    settle(50);
    chk("R3 no bytes", tx_n, 32'h0);
    chk("R3 no write-back", mem[30], 32'h0000_1234);
    mem[30] = OWN;
    clear_mon();
    reg_write(2'd1, 32'h0);
    settle(60);
    chk("R3 same descriptor count", tx_n, 32'd1);
    chk("R3 same descriptor byte", {24'b0, txb[0]}, 32'hA5);
  endtask

  task automatic t_chain();
    reg_write(2'd0, 32'd40);
    put_desc(40, OWN, FSEG | 32'd3, 32'd140);
    put_desc(44, OWN, LSEG | 32'd2, 32'd150);
    mem[48] = 32'h0;
    mem[140] = 32'h000C_0B0A; mem[150] = 32'h0000_0E0D;
    clear_mon();
    reg_write(2'd1, 32'h0);
    settle(120);
    chk("R8 bytes over two descriptors", tx_n, 32'd5);
    for (int i = 0; i < 5; i++) chk("R8 chained byte", {24'b0, txb[i]}, 32'h0A + i);
    chk("R5 one first flag", first_cnt, 32'd1);
    chk("R5 first at start", first_at, 32'd0);
    chk("R5 one last flag", last_cnt, 32'd1);
    chk("R5 last at end", last_at, 32'd4);
    chk("R8 second released", mem[44], 32'h0);
  endtask

  task automatic t_wrap();
    reg_write(2'd0, 32'd60);
    put_desc(60, OWN, FSEG | LSEG | EORF | 32'd1, 32'd160);
    put_desc(64, 32'h0000_0777, FSEG | LSEG | 32'd1, 32'd170);
    mem[160] = 32'h11; mem[161] = 32'h22; mem[170] = 32'h33;
    clear_mon();
    reg_write(2'd1, 32'h0);
    settle(60);
    chk("R10 fetch from written base", tx_n, 32'd1);
    chk("R10 base byte", {24'b0, txb[0]}, 32'h11);
    mem[60] = OWN; mem[62] = 32'd161;
    clear_mon();
    reg_write(2'd1, 32'h0);
    settle(60);
    chk("R9 wrapped fetch count", tx_n, 32'd1);
    chk("R9 wrapped byte", {24'b0, txb[0]}, 32'h22);
    chk("R9 next slot untouched", mem[64], 32'h0000_0777);
  endtask

  task automatic t_setup();
    int bad;
    reg_write(2'd0, 32'd80);
    put_desc(80, OWN, SETF | 32'd192, 32'd200);
    mem[84] = 32'h0;
    for (int w = 0; w < 48; w++)
      mem[200+w] = {setup_byte(4*w+3), setup_byte(4*w+2), setup_byte(4*w+1), setup_byte(4*w)};
    clear_mon();
    reg_write(2'd1, 32'h0);
    settle(400);
    chk("R6 filter byte count", flt_n, 32'd192);
    chk("R6 no transmit bytes", tx_n, 32'd0);
    bad = 0;
    for (int i = 0; i < 192; i++) if (fltb[i] !== setup_byte(i)) bad++;
    chk("R6 filter byte content", bad, 32'd0);
    chk("R7 setup completion", mem[80], 32'h0);
  endtask

  task automatic t_bad_len();
    reg_write(2'd0, 32'd300);
    put_desc(300, OWN, SETF | 32'd100, 32'd200);
    put_desc(304, OWN, FSEG | LSEG | 32'd0, 32'd200);
    mem[308] = 32'h0;
    clear_mon();
    reg_write(2'd1, 32'h0);
    settle(60);
    chk("R7 short setup error", mem[300], ESF);
    chk("R7 zero count error", mem[304], ESF);
    chk("R7 no filter bytes", flt_n, 32'd0);
    chk("R7 no transmit bytes", tx_n, 32'd0);
  endtask

  task automatic t_stop();
    reg_write(2'd0, 32'd320);
    put_desc(320, OWN, FSEG | LSEG | 32'd2, 32'd340);
    put_desc(324, OWN, FSEG | LSEG | 32'd2, 32'd341);
    mem[340] = 32'h0000_BBAA; mem[341] = 32'h0000_DDCC;
    clear_mon();
    reg_write(2'd1, 32'h0);
    reg_write(2'd2, 32'h0);
    settle(80);
    chk("R11 current frame finished", tx_n, 32'd2);
    chk("R11 current released", mem[320], 32'h0);
    chk("R11 next not fetched", mem[324], OWN);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) mem[i] = 32'h0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 2'd0; reg_wdata = 32'h0;
    clear_mon();
    settle(4);
    rst_n = 1'b1;
    t_reset();
    t_disabled();
    t_frame();
    t_sw_owned();
    t_chain();
    t_wrap();
    t_setup();
    t_bad_len();
    t_stop();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule